// File: doc/BRIEF.md
# Memory-to-Stream Read Channel

This block is one read channel of a simple DMA engine. Software sets a word-aligned start address and then writes a byte count. The count write starts the transfer. The channel then fetches one 32-bit word at a time from a request/response memory port and presents each word on a valid/ready stream with an end-of-packet marker. The address either steps one word per transfer or stays fixed, for a peripheral data port.

Each fetched word is added into a running 32-bit checksum before any reordering. A control bit can reverse the byte order of each outgoing word. Two independent pause bits hold back new fetches. A word that has already been fetched is still delivered. The block signals completion and memory errors with single-cycle pulses. Any interrupt logic around the block turns these pulses into interrupts.

Top module: `mm2s_read_channel`

## Requirements
- R1: After reset, `busy`, `done`, `rd_err`, `mem_req` and `m_valid` are low. `checksum` is zero. The control and status selections read as zero.
- R2: Register selects are 0 address-low, 1 address-high, 2 size, 3 control, 4 checksum and 5 status. Address-low keeps bits 31:2 and reads 0 in bits 1:0. Address-high keeps its low 17 bits as memory address bits 48:32. Address writes made while `busy` is high are ignored.
- R3: A size write keeps bits 28:2 as the word count and bit 0 as the last-word flag. A size read returns the remaining byte count in bits 28:2 and the flag in bit 0, with all other bits zero. A control read returns only bits 23, 22, 1 and 0.
- R4: A size write while idle with a nonzero count raises `busy` on the following cycle. A size write with a zero count pulses `done` for one cycle on the following cycle, issues no memory request and leaves `busy` low.
- R5: At most one memory read is outstanding. A presented word keeps `m_valid` high with stable data until `m_ready`. Every fetched word is delivered exactly once, in address order.
- R6: In incrementing mode, each delivered word advances the 49-bit address by 4, and the carry passes from the low register into the high register. With control bit 22 set, every request of the transfer uses the start address.
- R7: `m_last` is high only with the final word of a transfer, and only if the last-word flag was set.
- R8: When the final word is accepted, `busy` falls and `done` pulses for exactly one cycle.
- R9: While control bit 0 or control bit 1 is set, no new memory request is issued. Clearing both bits resumes the transfer and completes it.
- R10: Each error-free word read is added modulo 2^32 into `checksum`, using its value before any byte swap. Select 4 overwrites the checksum.
- R11: With control bit 23 set, byte 0 of each output word is the memory word's byte 3, byte 1 is byte 2, and so on.
- R12: A read returned with `mem_rerr` pulses `rd_err` once. The word is still delivered and counted as consumed, and it is not added to the checksum.
- R13: A size write while `busy` is ignored. If its count is nonzero, the sticky status bit 1 is set and stays set until reset. Status bit 0 mirrors `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_sel | input | 3 | Configuration register select |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Readback of the selected register |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | 49 | Byte address of the request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error flag |
| m_valid | output | 1 | Stream word valid |
| m_data | output | 32 | Stream word |
| m_last | output | 1 | End-of-packet marker |
| m_ready | input | 1 | Stream sink ready |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | One-cycle memory error pulse |
| checksum | output | 32 | Running additive checksum |

## Verification
The hardest states to reach are the overlaps: a size or address write landing mid-transfer, and a pause held while the stream sink stalls. To reach them, the bench throttles the sink to one cycle in five, which keeps a transfer open for a long time. It then issues the conflicting writes and reads back the sticky status, the request addresses and the delivered word count. A start address a few words below the 4 GiB boundary exercises the carry into the high address register. An error address placed on the middle word shows that the transfer still delivers that word and skips it in the checksum.

// File: rtl/mm2s_pkg.sv
package mm2s_pkg;
    localparam int DATA_W = 32;
    localparam int LO_W   = 32;
    localparam int HI_W   = 17;
    localparam int CNT_W  = 27;
    localparam int WA_W   = LO_W - 2 + HI_W;

    localparam int CTL_PAUSE_A = 0;
    localparam int CTL_PAUSE_B = 1;
    localparam int CTL_FIXED   = 22;
    localparam int CTL_SWAP    = 23;
    localparam logic [31:0] CTL_MASK = (32'd1 << CTL_PAUSE_A) | (32'd1 << CTL_PAUSE_B)
                                     | (32'd1 << CTL_FIXED) | (32'd1 << CTL_SWAP);

    typedef enum logic [2:0] {
        SEL_ADDR_LO = 3'd0,
        SEL_ADDR_HI = 3'd1,
        SEL_SIZE    = 3'd2,
        SEL_CTRL    = 3'd3,
        SEL_CSUM    = 3'd4,
        SEL_STATUS  = 3'd5
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_SEND
    } state_e;
endpackage

// File: rtl/mm2s_cursor.sv
module mm2s_cursor
    import mm2s_pkg::*;
#(
    parameter int P_LO_W  = LO_W,
    parameter int P_HI_W  = HI_W,
    parameter int P_CNT_W = CNT_W,
    localparam int P_WA_W = P_LO_W - 2 + P_HI_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lo_we,
    input  logic [P_LO_W-3:0]  lo_data,
    input  logic               hi_we,
    input  logic [P_HI_W-1:0]  hi_data,
    input  logic               load,
    input  logic [P_CNT_W-1:0] load_cnt,
    input  logic               load_last,
    input  logic               advance,
    input  logic               fixed,
    output logic [P_WA_W-1:0]  word_addr,
    output logic [P_CNT_W-1:0] count,
    output logic               last_flag,
    output logic               final_word
);
    typedef struct packed {
        logic [P_WA_W-1:0]  waddr;
        logic [P_CNT_W-1:0] cnt;
        logic               last;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (lo_we) cur_d.waddr[P_LO_W-3:0] = lo_data;
        if (hi_we) cur_d.waddr[P_WA_W-1:P_LO_W-2] = hi_data;
        if (load) begin
            cur_d.cnt  = load_cnt;
            cur_d.last = load_last;
        end
        if (advance) begin
            cur_d.cnt = cur_q.cnt - 1'b1;
            if (!fixed) cur_d.waddr = cur_q.waddr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign word_addr  = cur_q.waddr;
    assign count      = cur_q.cnt;
    assign last_flag  = cur_q.last;
    assign final_word = (cur_q.cnt == {{(P_CNT_W-1){1'b0}}, 1'b1});

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (count == $past(count) - 1'b1));

    // R6
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && fixed) |=> $stable(word_addr));
endmodule

// File: rtl/mm2s_word_path.sv
module mm2s_word_path
    import mm2s_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    localparam int BYTES   = P_DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [P_DATA_W-1:0] rdata,
    input  logic                rerr,
    input  logic                swap,
    input  logic                csum_we,
    input  logic [P_DATA_W-1:0] csum_wdata,
    output logic [P_DATA_W-1:0] data,
    output logic [P_DATA_W-1:0] csum
);
    typedef struct packed {
        logic [P_DATA_W-1:0] data;
        logic [P_DATA_W-1:0] csum;
    } wp_t;

    wp_t wp_d, wp_q;
    logic [P_DATA_W-1:0] swapped;
    logic [P_DATA_W-1:0] csum_base;

    for (genvar b = 0; b < BYTES; b++) begin : g_swap
        assign swapped[8*b +: 8] = rdata[8*(BYTES-1-b) +: 8];
    end

    always_comb begin
        wp_d      = wp_q;
        csum_base = csum_we ? csum_wdata : wp_q.csum;
        wp_d.csum = csum_base;
        if (capture) begin
            wp_d.data = swap ? swapped : rdata;
            if (!rerr) wp_d.csum = csum_base + rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wp_q <= '0;
        else        wp_q <= wp_d;
    end

    assign data = wp_q.data;
    assign csum = wp_q.csum;

    // R10
    csum_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !rerr && !csum_we) |=> (csum == $past(csum) + $past(rdata)));

    // R12
    csum_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && rerr && !csum_we) |=> $stable(csum));
endmodule

// File: rtl/mm2s_seq.sv
module mm2s_seq
    import mm2s_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic size_wr,
    input  logic size_zero,
    input  logic pause,
    input  logic final_word,
    input  logic mem_rvalid,
    input  logic mem_rerr,
    input  logic m_ready,
    output logic mem_req,
    output logic m_valid,
    output logic load,
    output logic capture,
    output logic advance,
    output logic busy,
    output logic done,
    output logic rd_err,
    output logic start_err
);
    typedef struct packed {
        state_e st;
        logic   done;
        logic   err;
        logic   sticky;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        sq_d.err  = 1'b0;
        load      = size_wr && (sq_q.st == ST_IDLE);
        capture   = (sq_q.st == ST_WAIT) && mem_rvalid;
        advance   = (sq_q.st == ST_SEND) && m_ready;
        mem_req   = (sq_q.st == ST_ISSUE) && !pause;
        unique case (sq_q.st)
            ST_IDLE: begin
                if (size_wr) begin
                    if (size_zero) sq_d.done = 1'b1;
                    else           sq_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: if (!pause) sq_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    sq_d.st  = ST_SEND;
                    sq_d.err = mem_rerr;
                end
            end
            ST_SEND: begin
                if (m_ready) begin
                    if (final_word) begin
                        sq_d.st   = ST_IDLE;
                        sq_d.done = 1'b1;
                    end else begin
                        sq_d.st = ST_ISSUE;
                    end
                end
            end
            default: sq_d.st = ST_IDLE;
        endcase
        if (size_wr && (sq_q.st != ST_IDLE) && !size_zero) sq_d.sticky = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '{st: ST_IDLE, done: 1'b0, err: 1'b0, sticky: 1'b0};
        else        sq_q <= sq_d;
    end

    assign m_valid   = (sq_q.st == ST_SEND);
    assign busy      = (sq_q.st != ST_IDLE);
    assign done      = sq_q.done;
    assign rd_err    = sq_q.err;
    assign start_err = sq_q.sticky;

    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R13
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(start_err));
endmodule

// File: rtl/mm2s_read_channel.sv
module mm2s_read_channel
    import mm2s_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 mem_req,
    output logic [WA_W+1:0]      mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_rerr,
    output logic                 m_valid,
    output logic [DATA_W-1:0]    m_data,
    output logic                 m_last,
    input  logic                 m_ready,
    output logic                 busy,
    output logic                 done,
    output logic                 rd_err,
    output logic [DATA_W-1:0]    checksum
);
    sel_e        sel;
    logic [31:0] ctrl_d, ctrl_q;
    logic        size_wr, load, capture, advance, start_err;
    logic        final_word, last_flag, pause;
    logic [WA_W-1:0]  word_addr;
    logic [CNT_W-1:0] count;

    assign sel     = sel_e'(reg_sel);
    assign size_wr = reg_we && (sel == SEL_SIZE);
    assign pause   = ctrl_q[CTL_PAUSE_A] | ctrl_q[CTL_PAUSE_B];

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we && (sel == SEL_CTRL)) ctrl_d = reg_wdata & CTL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    mm2s_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_wr    (size_wr),
        .size_zero  (reg_wdata[CNT_W+1:2] == '0),
        .pause      (pause),
        .final_word (final_word),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .m_ready    (m_ready),
        .mem_req    (mem_req),
        .m_valid    (m_valid),
        .load       (load),
        .capture    (capture),
        .advance    (advance),
        .busy       (busy),
        .done       (done),
        .rd_err     (rd_err),
        .start_err  (start_err)
    );

    mm2s_cursor u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_we      (reg_we && (sel == SEL_ADDR_LO) && !busy),
        .lo_data    (reg_wdata[LO_W-1:2]),
        .hi_we      (reg_we && (sel == SEL_ADDR_HI) && !busy),
        .hi_data    (reg_wdata[HI_W-1:0]),
        .load       (load),
        .load_cnt   (reg_wdata[CNT_W+1:2]),
        .load_last  (reg_wdata[0]),
        .advance    (advance),
        .fixed      (ctrl_q[CTL_FIXED]),
        .word_addr  (word_addr),
        .count      (count),
        .last_flag  (last_flag),
        .final_word (final_word)
    );

    mm2s_word_path u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .rdata      (mem_rdata),
        .rerr       (mem_rerr),
        .swap       (ctrl_q[CTL_SWAP]),
        .csum_we    (reg_we && (sel == SEL_CSUM)),
        .csum_wdata (reg_wdata),
        .data       (m_data),
        .csum       (checksum)
    );

    assign mem_addr = {word_addr, 2'b00};
    assign m_last   = m_valid && final_word && last_flag;

    always_comb begin
        unique case (sel)
            SEL_ADDR_LO: reg_rdata = {word_addr[LO_W-3:0], 2'b00};
            SEL_ADDR_HI: reg_rdata = {{(32-HI_W){1'b0}}, word_addr[WA_W-1:LO_W-2]};
            SEL_SIZE:    reg_rdata = {{(30-CNT_W){1'b0}}, count, 1'b0, last_flag};
            SEL_CTRL:    reg_rdata = ctrl_q;
            SEL_CSUM:    reg_rdata = checksum;
            SEL_STATUS:  reg_rdata = {30'd0, start_err, busy};
            default:     reg_rdata = '0;
        endcase
    end

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R7
    last_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_last && m_ready) |=> !busy);
endmodule

// File: tb/mm2s_read_channel_bench.sv
module mm2s_read_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_rvalid, mem_rerr;
    logic [48:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        m_valid, m_last, m_ready;
    logic [31:0] m_data;
    logic        busy, done, rd_err;
    logic [31:0] checksum;

    int checks = 0;
    int fails  = 0;
    int got_n = 0, req_n = 0, done_n = 0, err_n = 0;
    int rdy_mode = 0, mem_lat = 1, cyc = 0;
    logic [31:0] got_data [0:63];
    logic        got_last [0:63];
    logic [48:0] req_addr [0:63];
    logic [48:0] err_addr = '1;
    logic [48:0] cur_a;

    always #4 clk = ~clk;

    mm2s_read_channel u_mm2s_read_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_rerr(mem_rerr), .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
        .m_ready(m_ready), .busy(busy), .done(done), .rd_err(rd_err),
        .checksum(checksum)
    );

    function automatic logic [31:0] mem_word(input logic [48:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ {15'd0, a[48:32]};
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder
    initial begin
        mem_rvalid = 1'b0; mem_rdata = '0; mem_rerr = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                cur_a = mem_addr;
                req_addr[req_n % 64] = cur_a;
                req_n++;
                repeat (mem_lat) @(negedge clk);
                mem_rdata  = mem_word(cur_a);
                mem_rerr   = (cur_a == err_addr);
                mem_rvalid = 1'b1;
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rerr   = 1'b0;
            end
        end
    end

    // stream sink and pulse monitor
    initial begin
        m_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            case (rdy_mode)
                0:       m_ready = 1'b1;
                1:       m_ready = (cyc % 3) != 0;
                default: m_ready = (cyc % 5) == 4;
            endcase
            if (m_valid && m_ready) begin
                got_data[got_n % 64] = m_data;
                got_last[got_n % 64] = m_last;
                got_n++;
            end
            if (done)   done_n++;
            if (rd_err) err_n++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_n < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic start_xfer(input logic [16:0] hi, input logic [31:0] lo,
                              input logic [31:0] size_word, input logic [31:0] ctl,
                              input int rmode, input int lat, input logic [48:0] eaddr);
        rdy_mode = rmode; mem_lat = lat; err_addr = eaddr;
        @(negedge clk);
        got_n = 0; req_n = 0; done_n = 0; err_n = 0;
        reg_write(3'd4, 32'd0);
        reg_write(3'd3, ctl);
        reg_write(3'd1, {15'd0, hi});
        reg_write(3'd0, lo);
        reg_write(3'd2, size_word);
    endtask

    task automatic finish_check(input logic [16:0] hi, input logic [31:0] lo, input int n,
                                input bit last, input logic [31:0] ctl, input logic [48:0] eaddr);
        logic [48:0] base = {hi, lo[31:2], 2'b00};
        logic [31:0] exp_csum = 32'd0;
        int exp_err = 0;
        check(got_n == n, "R5", "words delivered", got_n, n);
        check(req_n == n, "R5", "memory requests", req_n, n);
        check(done_n == 1, "R8", "done pulses", done_n, 1);
        check(busy == 1'b0, "R8", "busy after done", busy, 0);
        for (int i = 0; i < n && i < 64; i++) begin
            logic [48:0] a = ctl[22] ? base : base + 49'(4 * i);
            logic [31:0] w = mem_word(a);
            logic [31:0] e = ctl[23] ? bswap(w) : w;
            check(req_addr[i] == a, ctl[22] ? "R6 fixed" : "R6 incr", "request address", req_addr[i], a);
            check(got_data[i] == e, ctl[23] ? "R11" : "R5", "word data", got_data[i], e);
            check(got_last[i] == (last && i == n - 1), "R7", "last marker", got_last[i], last && i == n - 1);
            if (a == eaddr) exp_err++;
            else exp_csum = exp_csum + w;
        end
        check(checksum == exp_csum, "R10", "checksum", checksum, exp_csum);
        check(err_n == exp_err, "R12", "error pulses", err_n, exp_err);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(busy == 0 && done == 0 && rd_err == 0, "R1", "status pins", {busy, done, rd_err}, 0);
        check(mem_req == 0 && m_valid == 0, "R1", "req/valid", {mem_req, m_valid}, 0);
        check(checksum == 0, "R1", "checksum", checksum, 0);
        reg_read(3'd5, v); check(v == 0, "R1", "status read", v, 0);
        reg_read(3'd3, v); check(v == 0, "R1", "control read", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_write(3'd0, 32'h1234_5677);
        reg_read(3'd0, v); check(v == 32'h1234_5674, "R2", "addr low mask", v, 32'h1234_5674);
        reg_write(3'd1, 32'hFFFF_FFFF);
        reg_read(3'd1, v); check(v == 32'h0001_FFFF, "R2", "addr high mask", v, 32'h0001_FFFF);
        reg_write(3'd3, 32'hFFFF_FFFF);
        reg_read(3'd3, v); check(v == 32'h00C0_0003, "R3", "control mask", v, 32'h00C0_0003);
        reg_write(3'd3, 32'd0);
        reg_write(3'd4, 32'hCAFE_0001);
        check(checksum == 32'hCAFE_0001, "R10", "checksum write", checksum, 32'hCAFE_0001);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        start_xfer(17'd0, 32'h0000_1000, 32'd17, 32'd0, 0, 1, '1);
        check(busy == 1'b1, "R4", "busy after start", busy, 1);
        wait_done(1);
        finish_check(17'd0, 32'h0000_1000, 4, 1'b1, 32'd0, '1);
        reg_read(3'd0, v); check(v == 32'h0000_1010, "R6", "final address", v, 32'h0000_1010);
        reg_read(3'd2, v); check(v == 32'h0000_0001, "R3", "size after", v, 1);
    endtask

    task automatic t_carry();
        logic [31:0] v;
        start_xfer(17'h00003, 32'hFFFF_FFF8, 32'd16, 32'd0, 1, 2, '1);
        wait_done(1);
        finish_check(17'h00003, 32'hFFFF_FFF8, 4, 1'b0, 32'd0, '1);
        reg_read(3'd1, v); check(v == 32'h4, "R6", "high carry", v, 4);
    endtask

    task automatic t_fixed();
        start_xfer(17'h00010, 32'h0000_0400, 32'd13, 32'h0040_0000, 2, 3, '1);
        wait_done(1);
        finish_check(17'h00010, 32'h0000_0400, 3, 1'b1, 32'h0040_0000, '1);
    endtask

    task automatic t_swap();
        start_xfer(17'd0, 32'h0000_2000, 32'd8, 32'h0080_0000, 0, 1, '1);
        wait_done(1);
        finish_check(17'd0, 32'h0000_2000, 2, 1'b0, 32'h0080_0000, '1);
    endtask

    task automatic t_pause();
        logic [31:0] v;
        start_xfer(17'd0, 32'h0000_3000, 32'hE000_0009, 32'h0000_0001, 0, 1, '1);
        repeat (30) @(negedge clk);
        check(req_n == 0, "R9", "no request while pause bit 0", req_n, 0);
        check(busy == 1'b1 && m_valid == 1'b0, "R9", "held busy", {busy, m_valid}, 2'b10);
        reg_read(3'd2, v); check(v == 32'h0000_0009, "R3", "size readback", v, 9);
        reg_write(3'd3, 32'h0000_0002);
        repeat (20) @(negedge clk);
        check(req_n == 0, "R9", "no request while pause bit 1", req_n, 0);
        reg_write(3'd3, 32'd0);
        wait_done(1);
        finish_check(17'd0, 32'h0000_3000, 2, 1'b1, 32'd0, '1);
    endtask

    task automatic t_zero();
        got_n = 0; req_n = 0; done_n = 0;
        reg_write(3'd2, 32'h0000_0001);
        check(done == 1'b1, "R4", "zero size done", done, 1);
        check(busy == 1'b0, "R4", "zero size busy", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R4", "done single cycle", done, 0);
        repeat (10) @(negedge clk);
        check(req_n == 0 && got_n == 0, "R4", "zero size moves nothing", req_n + got_n, 0);
    endtask

    task automatic t_busy_write();
        logic [31:0] v;
        reg_read(3'd5, v); check(v[1] == 1'b0, "R13", "sticky clear before", v, 0);
        start_xfer(17'd0, 32'h0000_4000, 32'd24, 32'd0, 2, 1, '1);
        repeat (3) @(negedge clk);
        reg_write(3'd2, 32'd16);
        reg_write(3'd0, 32'h0000_8000);
        reg_write(3'd2, 32'd0);
        reg_read(3'd5, v); check(v == 32'h3, "R13", "status busy+sticky", v, 3);
        wait_done(1);
        repeat (5) @(negedge clk);
        finish_check(17'd0, 32'h0000_4000, 6, 1'b0, 32'd0, '1);
        reg_read(3'd0, v); check(v == 32'h0000_4018, "R2", "addr write ignored while busy", v, 32'h4018);
        reg_read(3'd5, v); check(v == 32'h2, "R13", "sticky stays", v, 2);
    endtask

    task automatic t_err();
        start_xfer(17'd0, 32'h0000_5000, 32'd12, 32'd0, 0, 1, 49'h0_0000_0000_5004);
        wait_done(1);
        finish_check(17'd0, 32'h0000_5000, 3, 1'b0, 32'd0, 49'h0_0000_0000_5004);
    endtask

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_carry();
        t_fixed();
        t_swap();
        t_pause();
        t_zero();
        t_busy_write();
        t_err();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule